// File: doc/BRIEF.md
# Pseudo-Channel Request Steering and Admission

This block sits at the front of a memory controller that drives two pseudo channels. These channels have separate data paths but share command resources. Each cycle the block may receive one read or write request, given as a byte address and a byte size. One address bit steers the request to pseudo channel 0 or 1. The block works out how many memory bursts the request occupies. It then decides at once, in the same cycle, whether the target channel has room for that many bursts. An accepted request is announced with an enqueue strobe, the channel id and the burst count. A request with no room is refused.

The block keeps occupancy counters for each channel: queued reads, reads whose responses are still pending, and queued writes. The scheduler behind the block reports three events per channel: a read moving from the queue to the response stage, a completed read response, and a completed write. The counters follow those events. Queue capacity works in one of two modes. In split mode, each channel may use half of the combined buffer. In shared mode, both channels draw on the combined buffer. A refusal arms a retry flag for that channel and direction. The next time that channel frees an entry of that direction, the block emits a single retry pulse upstream. The block also raises write-drain marks from the write occupancy.

Top module: `pc_admit`

## Requirements
- R1: Address bit SEL_BIT (default 6) picks the channel. A 0 there routes the request to channel 0 and a 1 routes it to channel 1. `acc_chan` carries that value, and the accepted bursts are added to that channel's counters only.
- R2: `acc_bursts` equals ceil((offset + size) / BURST_BYTES), where offset = address mod BURST_BYTES (default 32 bytes). Size is at least 1.
- R3: While `req_valid` is high, exactly one of `acc_valid` and `req_refused` is high in the same cycle. Both are low while `req_valid` is low.
- R4: Split mode (`cfg_split`=1), writes: a write is refused when the channel's queued writes plus the needed bursts exceed half the total write capacity. The total write capacity is 2×WR_BUF_PC, which is 16 by default, so half is 8.
- R5: Split mode, reads: a read is refused when the channel's queued reads plus its pending responses plus the needed bursts exceed half the total read capacity. The total read capacity is 2×RD_BUF_PC, which is 16 by default, so half is 8.
- R6: Shared mode (`cfg_split`=0): a read is refused when the queued reads and pending responses of both channels plus the needed bursts exceed the total read capacity. A write is refused when the queued writes of both channels plus the needed bursts exceed the total write capacity.
- R7: At each clock edge, an accepted request adds its bursts to its channel's read queue or write queue. `rd_issue[c]` moves one entry of channel c from queued to pending. `rd_done[c]` removes one pending entry, and `wr_done[c]` removes one queued write. All of these apply together in the same cycle. An `rd_issue`, `rd_done` or `wr_done` whose counter is zero is ignored.
- R8: A refused read to channel c arms that channel's read retry flag, and a refused write arms its write retry flag. A flag is released by a real free of that channel and direction: `rd_done[c]` for reads, `wr_done[c]` for writes. When an armed flag is released, `retry_rd[c]` or `retry_wr[c]` is high for exactly the next cycle and the flag clears. A refusal in the same cycle as the free re-arms the flag. A free with no armed flag gives no pulse.
- R9: `wr_drain_hi[c]` is high when the observed write count is at or above the high mark. `wr_drain_lo[c]` is high when that count is below the low mark. In split mode the observed count is channel c's own writes, and the marks are floor(WR_TOT×floor(PCT/2)/100): 6 high and 4 low by default. In shared mode both bits observe the sum over both channels, and the marks are floor(WR_TOT×PCT/100): 13 and 8 by default. The defaults use PCT 85 and 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_split | input | 1 | 1 = split capacity per channel, 0 = shared capacity |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | SIZE_W | Request size in bytes (at least 1) |
| rd_issue | input | 2 | Per channel: one queued read moves to the response stage |
| rd_done | input | 2 | Per channel: one pending read response completes |
| wr_done | input | 2 | Per channel: one queued write completes |
| acc_valid | output | 1 | Enqueue strobe for an accepted request |
| acc_chan | output | 1 | Selected pseudo channel |
| acc_bursts | output | NB_W | Number of bursts the request needs |
| req_refused | output | 1 | Request refused for lack of room |
| retry_rd | output | 2 | Per channel one-cycle read retry pulse |
| retry_wr | output | 2 | Per channel one-cycle write retry pulse |
| wr_drain_hi | output | 2 | Write count at or above the high drain mark |
| wr_drain_lo | output | 2 | Write count below the low drain mark |

## Verification
A refusal and a free of the same channel and direction can fall in the same cycle. The bench provokes this on purpose by filling a channel to its limit and then offering another request while asserting the matching `wr_done` or `rd_done`. The reference model judges the result. It expects the retry pulse from the earlier refusal in the next cycle, with the flag re-armed by the new refusal and a second pulse after the next free. Acceptance and counter movements also coincide: a request is admitted against the counters from before the edge, while dequeues in that same cycle take effect only after it. Random traffic with heavy request rates keeps both channels at their limits so that these collisions recur.

// File: rtl/pc_admit_pkg.sv
package pc_admit_pkg;

  function automatic int unsigned pct_of(input int unsigned total,
                                         input int unsigned pct);
    return (total * pct) / 100;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

endpackage

// File: rtl/pc_burst_calc.sv
module pc_burst_calc #(
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 32,
  parameter int NB_W        = 4
) (
  input  logic [$clog2(BURST_BYTES)-1:0] ofs,
  input  logic [SIZE_W-1:0]              size,
  output logic [NB_W-1:0]                bursts
);
  localparam int OFS_W = $clog2(BURST_BYTES);
  localparam int SPAN_W = pc_admit_pkg::max2(OFS_W, SIZE_W) + 2;

  logic [SPAN_W-1:0] span;

  always_comb begin
    span   = SPAN_W'(ofs) + SPAN_W'(size) + SPAN_W'(BURST_BYTES - 1);
    bursts = NB_W'(span[SPAN_W-1:OFS_W]);
  end
endmodule

// File: rtl/pc_admit_gate.sv
module pc_admit_gate #(
  parameter int CNT_W  = 5,
  parameter int NB_W   = 4,
  parameter int CMP_W  = 8,
  parameter int RD_TOT = 16,
  parameter int WR_TOT = 16
) (
  input  logic                  split,
  input  logic                  is_wr,
  input  logic                  chan,
  input  logic [NB_W-1:0]       need,
  input  logic [1:0][CNT_W-1:0] rdq,
  input  logic [1:0][CNT_W-1:0] rsp,
  input  logic [1:0][CNT_W-1:0] wrq,
  output logic                  room
);
  localparam logic [CMP_W-1:0] RD_LIM_SPLIT = CMP_W'(RD_TOT / 2);
  localparam logic [CMP_W-1:0] WR_LIM_SPLIT = CMP_W'(WR_TOT / 2);
  localparam logic [CMP_W-1:0] RD_LIM_ALL   = CMP_W'(RD_TOT);
  localparam logic [CMP_W-1:0] WR_LIM_ALL   = CMP_W'(WR_TOT);

  logic [CMP_W-1:0] rd_own, rd_all, wr_own, wr_all, occ, lim;

  always_comb begin
    rd_own = CMP_W'(rdq[chan]) + CMP_W'(rsp[chan]);
    rd_all = CMP_W'(rdq[0]) + CMP_W'(rdq[1]) + CMP_W'(rsp[0]) + CMP_W'(rsp[1]);
    wr_own = CMP_W'(wrq[chan]);
    wr_all = CMP_W'(wrq[0]) + CMP_W'(wrq[1]);
    if (is_wr) begin
      occ = split ? wr_own : wr_all;
      lim = split ? WR_LIM_SPLIT : WR_LIM_ALL;
    end else begin
      occ = split ? rd_own : rd_all;
      lim = split ? RD_LIM_SPLIT : RD_LIM_ALL;
    end
    room = (occ + CMP_W'(need)) <= lim;
  end
endmodule

// File: rtl/pc_chan_track.sv
module pc_chan_track #(
  parameter int CNT_W = 5,
  parameter int NB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_rd,
  input  logic             add_wr,
  input  logic [NB_W-1:0]  nb,
  input  logic             issue_rd,
  input  logic             done_rd,
  input  logic             done_wr,
  output logic [CNT_W-1:0] rdq,
  output logic [CNT_W-1:0] rsp,
  output logic [CNT_W-1:0] wrq,
  output logic             rd_freed,
  output logic             wr_freed
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             issue_ok, upd;
  logic [CNT_W-1:0] add_amt, rdq_n, rsp_n, wrq_n;

  always_comb begin
    add_amt  = CNT_W'(nb);
    issue_ok = issue_rd && (rdq != '0);
    rd_freed = done_rd && (rsp != '0);
    wr_freed = done_wr && (wrq != '0);

    rdq_n = rdq;
    if (add_rd)   rdq_n = rdq_n + add_amt;
    if (issue_ok) rdq_n = rdq_n - ONE;

    rsp_n = rsp;
    if (issue_ok) rsp_n = rsp_n + ONE;
    if (rd_freed) rsp_n = rsp_n - ONE;

    wrq_n = wrq;
    if (add_wr)   wrq_n = wrq_n + add_amt;
    if (wr_freed) wrq_n = wrq_n - ONE;

    upd = add_rd | add_wr | issue_ok | rd_freed | wr_freed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdq <= '0;
      rsp <= '0;
      wrq <= '0;
    end else if (upd) begin
      rdq <= rdq_n;
      rsp <= rsp_n;
      wrq <= wrq_n;
    end
  end
endmodule

// File: rtl/pc_retry_flag.sv
module pc_retry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic freed,
  output logic pulse
);
  logic armed, armed_n, pulse_n, upd;

  always_comb begin
    pulse_n = armed & freed;
    armed_n = arm | (armed & ~freed);
    upd     = arm | freed | armed | pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pulse <= 1'b0;
    end else if (upd) begin
      armed <= armed_n;
      pulse <= pulse_n;
    end
  end
endmodule

// File: rtl/pc_admit.sv
module pc_admit #(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 32,
  parameter int SEL_BIT     = 6,
  parameter int RD_BUF_PC   = 8,
  parameter int WR_BUF_PC   = 8,
  parameter int WR_HI_PCT   = 85,
  parameter int WR_LO_PCT   = 50,
  localparam int NB_W = $clog2((2 * BURST_BYTES + (1 << SIZE_W) - 3) / BURST_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        rd_issue,
  input  logic [1:0]        rd_done,
  input  logic [1:0]        wr_done,
  output logic              acc_valid,
  output logic              acc_chan,
  output logic [NB_W-1:0]   acc_bursts,
  output logic              req_refused,
  output logic [1:0]        retry_rd,
  output logic [1:0]        retry_wr,
  output logic [1:0]        wr_drain_hi,
  output logic [1:0]        wr_drain_lo
);
  import pc_admit_pkg::*;

  localparam int OFS_W  = $clog2(BURST_BYTES);
  localparam int RD_TOT = 2 * RD_BUF_PC;
  localparam int WR_TOT = 2 * WR_BUF_PC;
  localparam int CNT_W  = $clog2(max2(RD_TOT, WR_TOT) + 1);
  localparam int CMP_W  = max2(CNT_W, NB_W) + 3;
  localparam logic [CMP_W-1:0] HI_SPLIT = CMP_W'(pct_of(WR_TOT, WR_HI_PCT / 2));
  localparam logic [CMP_W-1:0] LO_SPLIT = CMP_W'(pct_of(WR_TOT, WR_LO_PCT / 2));
  localparam logic [CMP_W-1:0] HI_ALL   = CMP_W'(pct_of(WR_TOT, WR_HI_PCT));
  localparam logic [CMP_W-1:0] LO_ALL   = CMP_W'(pct_of(WR_TOT, WR_LO_PCT));

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic addr_unused;
  assign addr_unused = ^req_addr;

  logic [NB_W-1:0]       need;
  logic                  room;
  logic [1:0][CNT_W-1:0] rdq_cnt, rsp_cnt, wrq_cnt;
  logic [1:0]            rd_freed, wr_freed;
  dir_e                  dir;

  assign dir = req_write ? DIR_WR : DIR_RD;

  pc_burst_calc #(.SIZE_W(SIZE_W), .BURST_BYTES(BURST_BYTES), .NB_W(NB_W)) u_burst (
    .ofs(req_addr[OFS_W-1:0]), .size(req_size), .bursts(need));

  pc_admit_gate #(.CNT_W(CNT_W), .NB_W(NB_W), .CMP_W(CMP_W),
                  .RD_TOT(RD_TOT), .WR_TOT(WR_TOT)) u_gate (
    .split(cfg_split), .is_wr(dir == DIR_WR), .chan(req_addr[SEL_BIT]),
    .need(need), .rdq(rdq_cnt), .rsp(rsp_cnt), .wrq(wrq_cnt), .room(room));

  always_comb begin
    acc_chan    = req_addr[SEL_BIT];
    acc_bursts  = need;
    acc_valid   = req_valid & room;
    req_refused = req_valid & ~room;
  end

  logic [CMP_W-1:0] wr_sum;
  assign wr_sum = CMP_W'(wrq_cnt[0]) + CMP_W'(wrq_cnt[1]);

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic             hit, add_rd, add_wr, rej_rd, rej_wr;
    logic [CMP_W-1:0] obs;

    always_comb begin
      hit    = (acc_chan == c[0]);
      add_rd = acc_valid   & hit & (dir == DIR_RD);
      add_wr = acc_valid   & hit & (dir == DIR_WR);
      rej_rd = req_refused & hit & (dir == DIR_RD);
      rej_wr = req_refused & hit & (dir == DIR_WR);
      obs    = cfg_split ? CMP_W'(wrq_cnt[c]) : wr_sum;
      wr_drain_hi[c] = obs >= (cfg_split ? HI_SPLIT : HI_ALL);
      wr_drain_lo[c] = obs <  (cfg_split ? LO_SPLIT : LO_ALL);
    end

    pc_chan_track #(.CNT_W(CNT_W), .NB_W(NB_W)) u_track (
      .clk(clk), .rst_n(rst_core_n), .add_rd(add_rd), .add_wr(add_wr),
      .nb(need), .issue_rd(rd_issue[c]), .done_rd(rd_done[c]),
      .done_wr(wr_done[c]), .rdq(rdq_cnt[c]), .rsp(rsp_cnt[c]),
      .wrq(wrq_cnt[c]), .rd_freed(rd_freed[c]), .wr_freed(wr_freed[c]));

    pc_retry_flag u_rty_rd (.clk(clk), .rst_n(rst_core_n), .arm(rej_rd),
                            .freed(rd_freed[c]), .pulse(retry_rd[c]));
    pc_retry_flag u_rty_wr (.clk(clk), .rst_n(rst_core_n), .arm(rej_wr),
                            .freed(wr_freed[c]), .pulse(retry_wr[c]));
  end
endmodule

// File: rtl/pc_admit_chk.sv
module pc_admit_chk #(
  parameter int CNT_W  = 5,
  parameter int NB_W   = 4,
  parameter int RD_TOT = 16,
  parameter int WR_TOT = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_split,
  input logic                  req_valid,
  input logic                  req_write,
  input logic                  req_sel,
  input logic                  rd_issue1,
  input logic [1:0]            rd_done,
  input logic [1:0]            wr_done,
  input logic                  acc_valid,
  input logic [NB_W-1:0]       acc_bursts,
  input logic                  req_refused,
  input logic [1:0]            retry_rd,
  input logic [1:0]            retry_wr,
  input logic [1:0][CNT_W-1:0] rdq,
  input logic [1:0][CNT_W-1:0] rsp,
  input logic [1:0][CNT_W-1:0] wrq
);
  localparam int SW = CNT_W + 3;
  logic [SW-1:0] rd0, rd1, rd_all, wr_all;
  always_comb begin
    rd0    = SW'(rdq[0]) + SW'(rsp[0]);
    rd1    = SW'(rdq[1]) + SW'(rsp[1]);
    rd_all = rd0 + rd1;
    wr_all = SW'(wrq[0]) + SW'(wrq[1]);
  end

  // R1 / R7: accepted bursts land in the selected channel
  a_r1_wr_route_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && req_write && !req_sel && !wr_done[0])
      |=> wrq[0] == $past(wrq[0]) + CNT_W'($past(acc_bursts)));
  a_r1_rd_route_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !req_write && req_sel && !rd_issue1)
      |=> rdq[1] == $past(rdq[1]) + CNT_W'($past(acc_bursts)));
  // R3
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (acc_valid ^ req_refused));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(acc_valid || req_refused));
  // R4
  a_r4_split_wr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_split |-> (SW'(wrq[0]) <= SW'(WR_TOT / 2)) && (SW'(wrq[1]) <= SW'(WR_TOT / 2)));
  // R5
  a_r5_split_rd_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_split |-> (rd0 <= SW'(RD_TOT / 2)) && (rd1 <= SW'(RD_TOT / 2)));
  // R6
  a_r6_shared_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_all <= SW'(RD_TOT)) && (wr_all <= SW'(WR_TOT)));
  // R8: a pulse follows a free of that channel and direction
  a_r8_rd0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_rd[0] |-> $past(rd_done[0]));
  a_r8_rd1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_rd[1] |-> $past(rd_done[1]));
  a_r8_wr0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_wr[0] |-> $past(wr_done[0]));
  a_r8_wr1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    retry_wr[1] |-> $past(wr_done[1]));
endmodule

bind pc_admit pc_admit_chk #(.CNT_W(CNT_W), .NB_W(NB_W), .RD_TOT(RD_TOT), .WR_TOT(WR_TOT)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cfg_split(cfg_split), .req_valid(req_valid),
  .req_write(req_write), .req_sel(req_addr[SEL_BIT]), .rd_issue1(rd_issue[1]),
  .rd_done(rd_done), .wr_done(wr_done), .acc_valid(acc_valid),
  .acc_bursts(acc_bursts), .req_refused(req_refused), .retry_rd(retry_rd),
  .retry_wr(retry_wr), .rdq(rdq_cnt), .rsp(rsp_cnt), .wrq(wrq_cnt));

// File: tb/sim_pc_admit.sv
`timescale 1ns/1ps
module sim_pc_admit;
  localparam int BURST = 32;
  localparam int RDT   = 16;
  localparam int WRT   = 16;

  logic        clk, rst_n, cfg_split, req_valid, req_write;
  logic [31:0] req_addr;
  logic [7:0]  req_size;
  logic [1:0]  rd_issue, rd_done, wr_done;
  logic        acc_valid, acc_chan, req_refused;
  logic [3:0]  acc_bursts;
  logic [1:0]  retry_rd, retry_wr, wr_drain_hi, wr_drain_lo;

  pc_admit u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  string tag_force = "";

  int rq[2], rs[2], wq[2];
  bit frd[2], fwr[2], erd[2], ewr[2];

  task automatic chk(input bit good, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int f_bursts(input logic [31:0] a, input int sz);
    return ((a % BURST) + sz + BURST - 1) / BURST;
  endfunction

  function automatic bit f_room(input bit w, input int ch, input int nb);
    int occ, lim;
    if (w) begin
      occ = cfg_split ? wq[ch] : wq[0] + wq[1];
      lim = cfg_split ? WRT / 2 : WRT;
    end else begin
      occ = cfg_split ? rq[ch] + rs[ch] : rq[0] + rq[1] + rs[0] + rs[1];
      lim = cfg_split ? RDT / 2 : RDT;
    end
    return (occ + nb) <= lim;
  endfunction

  function automatic int f_mark(input int pct);
    return cfg_split ? (WRT * (pct / 2)) / 100 : (WRT * pct) / 100;
  endfunction

  task automatic clear_model();
    for (int c = 0; c < 2; c++) begin
      rq[c] = 0; rs[c] = 0; wq[c] = 0;
      frd[c] = 0; fwr[c] = 0; erd[c] = 0; ewr[c] = 0;
    end
  endtask

  task automatic step(input bit v, input bit w, input logic [31:0] a, input int sz,
                      input logic [1:0] iss, input logic [1:0] rdd, input logic [1:0] wrd);
    int ch, nb, obs;
    bit ok;
    string tag;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk(retry_rd[c] === erd[c], "R8", "retry_rd", int'(retry_rd[c]), int'(erd[c]));
      chk(retry_wr[c] === ewr[c], "R8", "retry_wr", int'(retry_wr[c]), int'(ewr[c]));
      obs = cfg_split ? wq[c] : wq[0] + wq[1];
      chk(wr_drain_hi[c] === (obs >= f_mark(85)), "R9", "drain_hi",
          int'(wr_drain_hi[c]), int'(obs >= f_mark(85)));
      chk(wr_drain_lo[c] === (obs < f_mark(50)), "R9", "drain_lo",
          int'(wr_drain_lo[c]), int'(obs < f_mark(50)));
    end
    req_valid = v; req_write = w; req_addr = a; req_size = 8'(sz);
    rd_issue = iss; rd_done = rdd; wr_done = wrd;
    #1;
    ch = int'(a[6]);
    nb = f_bursts(a, sz);
    ok = f_room(w, ch, nb);
    if (tag_force != "") tag = tag_force;
    else if (!cfg_split) tag = "R6";
    else tag = w ? "R4" : "R5";
    chk(acc_valid === (v && ok), tag, "acc_valid", int'(acc_valid), int'(v && ok));
    chk(req_refused === (v && !ok), "R3", "req_refused", int'(req_refused), int'(v && !ok));
    if (v) begin
      chk(acc_chan === a[6], "R1", "acc_chan", int'(acc_chan), ch);
      chk(int'(acc_bursts) == nb, "R2", "acc_bursts", int'(acc_bursts), nb);
    end
    for (int c = 0; c < 2; c++) begin
      bit iok, rfr, wfr, hit;
      iok = iss[c] && rq[c] > 0;
      rfr = rdd[c] && rs[c] > 0;
      wfr = wrd[c] && wq[c] > 0;
      hit = v && (ch == c);
      erd[c] = frd[c] && rfr;
      ewr[c] = fwr[c] && wfr;
      frd[c] = (hit && !ok && !w) || (frd[c] && !rfr);
      fwr[c] = (hit && !ok && w) || (fwr[c] && !wfr);
      rq[c] = rq[c] + ((hit && ok && !w) ? nb : 0) - int'(iok);
      rs[c] = rs[c] + int'(iok) - int'(rfr);
      wq[c] = wq[c] + ((hit && ok && w) ? nb : 0) - int'(wfr);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic drain_all();
    for (int i = 0; i < 60; i++) step(0, 0, 0, 1, 2'b11, 2'b11, 2'b11);
    idle(2);
  endtask

  task automatic do_reset(input bit split);
    @(negedge clk);
    rst_n = 0; cfg_split = split;
    req_valid = 0; req_write = 0; req_addr = 0; req_size = 1;
    rd_issue = 0; rd_done = 0; wr_done = 0;
    clear_model();
    repeat (3) @(negedge clk);
    chk(retry_rd === 2'b00 && retry_wr === 2'b00, "R8", "reset retry",
        int'({retry_rd, retry_wr}), 0);
    chk(wr_drain_lo === 2'b11 && wr_drain_hi === 2'b00, "R9", "reset drain",
        int'({wr_drain_hi, wr_drain_lo}), 3);
    rst_n = 1;
    idle(4);
  endtask

  task automatic random_phase(input int n);
    for (int i = 0; i < n; i++) begin
      int sz;
      sz = ($urandom_range(0, 9) < 8) ? $urandom_range(1, 64) : $urandom_range(1, 255);
      step($urandom_range(0, 99) < 75, $urandom_range(0, 1) == 1, $urandom, sz,
           {$urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3},
           {$urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3},
           {$urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3});
    end
  endtask

  initial begin
    void'($urandom(32'h5A17_C0DE));
    rst_n = 0;
    do_reset(1'b1);

    // R2: burst counts across offsets and sizes
    tag_force = "R2";
    step(1, 1, 32'h0000_001F, 2, 0, 0, 0);
    step(1, 1, 32'h0000_0040, 32, 0, 0, 0);
    step(1, 0, 32'h0000_0045, 59, 0, 0, 0);
    step(1, 0, 32'h0000_0000, 33, 0, 0, 0);
    step(1, 0, 32'h0000_0000, 1, 0, 0, 0);
    drain_all();

    // R7: frees on empty counters are ignored; limit stays exact afterwards
    tag_force = "R7";
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 2'b11, 2'b11, 2'b11);
    for (int i = 0; i < 8; i++) step(1, 1, 32'h0000_0080, 32, 0, 0, 0);
    tag_force = "";
    // R4: ninth burst refused, then refusal colliding with a free (R8)
    step(1, 1, 32'h0000_0080, 32, 0, 0, 0);
    step(1, 1, 32'h0000_0080, 32, 0, 0, 2'b01);
    step(0, 0, 0, 1, 0, 0, 2'b01);
    idle(2);
    // R5: channel 1 reads with pending responses
    for (int i = 0; i < 4; i++) step(1, 0, 32'h0000_0040, 64, 0, 0, 0);
    step(0, 0, 0, 1, 2'b10, 0, 0);
    step(1, 0, 32'h0000_0040, 1, 2'b10, 0, 0);
    step(0, 0, 0, 1, 0, 2'b10, 0);
    idle(2);
    step(0, 0, 0, 1, 0, 2'b10, 0);
    drain_all();

    random_phase(1500);
    drain_all();

    // R6: shared capacity
    do_reset(1'b0);
    for (int i = 0; i < 16; i++) step(1, 1, 32'h0000_0000, 32, 0, 0, 0);
    step(1, 1, 32'h0000_0040, 1, 0, 0, 0);
    step(1, 0, 32'h0000_0040, 255, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 2'b01);
    idle(2);
    for (int i = 0; i < 8; i++) step(1, 0, 32'h0000_0040 * (i % 2), 64, 0, 0, 0);
    step(1, 0, 32'h0000_0000, 1, 2'b11, 0, 0);
    step(0, 0, 0, 1, 0, 2'b01, 0);
    drain_all();

    random_phase(1500);
    drain_all();

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule